// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

The resolver gathers eight interrupt request lines, each programmable as edge or level sensitive, into a request register. Pending requests that are not masked compete under a circular priority order whose starting point (the priority base) can be moved. The winner is also compared with the lines already being serviced. The single interrupt output is raised only when the pending winner outranks every in-service line that counts.

A processor-side agent pulses an acknowledge strobe. The block answers with a valid flag and the winning line number, and records that line as in service. Alternatively, in automatic end-of-interrupt mode, it records nothing and may rotate the priority base. Software-style commands arrive on a small command port, with no address decoding. They end service either for the top in-service line or for a named line, with or without rotation, and they can also place the priority base directly. Three static mode inputs change which in-service lines take part in the comparison and whether acknowledges auto-complete: special mask, nested cascade master, and automatic end-of-interrupt.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset, the following are all zero: the request, in-service, mask and trigger registers, the priority base, the interrupt output and the acknowledge valid flag. All lines start edge sensitive.
- R2: For an edge line (trigger bit 0), a request bit is set when the sampled input is high and the previously sampled input was low. Holding the input high does not set it again. For a level line (trigger bit 1), the request bit takes the sampled input level on every clock.
- R3: Priority p belongs to line (p + base) mod 8, and p = 0 ranks highest. An acknowledge returns the highest-priority unmasked pending line on ackLine, with ackValid high, one cycle after the strobe.
- R4: intOut is registered and follows the current state one cycle later. It is high only if an unmasked request exists and its priority number is strictly smaller than that of the best in-service line that counts.
- R5: With modeSpecialMask high, in-service lines whose mask bit is set do not count. With modeNested and isMaster both high, in-service line 2 does not count.
- R6: When automatic end-of-interrupt is off, an acknowledge sets the winner's in-service bit. When it is on, no in-service bit is set. If rotate-on-auto-EOI is also enabled, the base becomes winner+1 mod 8. Command op 6 enables rotate-on-auto-EOI and op 7 disables it.
- R7: An acknowledge clears the winner's request bit if the line is edge sensitive and leaves it unchanged if the line is level sensitive.
- R8: Op 1 clears the in-service bit of highest priority. Op 2 does the same and also sets the base to that line+1 mod 8. Neither op does anything when no bit is in service.
- R9: Op 3 clears the in-service bit selected by cmdLine. Op 4 clears that bit and sets the base to cmdLine+1. Op 5 only sets the base to cmdLine+1. All arithmetic is mod 8, and op 0 does nothing.
- R10: A trigger write stores trigIn AND TRIG_WRITABLE (default 8'hFC), so lines 0 and 1 always stay edge sensitive.
- R11: A mask bit of 1 stops the line from raising intOut or winning an acknowledge. An acknowledge with no winner gives ackValid 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | 8 | Interrupt request lines |
| maskWe | input | 1 | Load mask register from maskIn |
| maskIn | input | 8 | New mask value (1 = masked) |
| trigWe | input | 1 | Load trigger register from trigIn |
| trigIn | input | 8 | New trigger selection (1 = level) |
| modeSpecialMask | input | 1 | Special mask mode |
| modeNested | input | 1 | Nested cascade mode |
| isMaster | input | 1 | Block acts as cascade master |
| modeAutoEoi | input | 1 | Automatic end-of-interrupt |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command operation code |
| cmdLine | input | 3 | Line field of the command |
| ackStrobe | input | 1 | Acknowledge strobe |
| intOut | output | 1 | Interrupt output |
| ackValid | output | 1 | Acknowledge produced a winner |
| ackLine | output | 3 | Winning line number |
| reqOut | output | 8 | Request register read-back |
| svcOut | output | 8 | In-service register read-back |
| trigOut | output | 8 | Trigger register read-back |
| baseOut | output | 3 | Priority base read-back |

## Verification
The bench runs an exhaustive sweep over all 256 request patterns under each of the eight priority bases. It drains every pattern through repeated acknowledges, so a resolver with an off-by-one in the rotation or a reversed search would return lines in the wrong order. Directed cases check that a pending line of equal priority to an in-service line keeps intOut low; a non-strict comparison would re-interrupt the same level. Special mask, nested master, forced-edge lines and held level inputs are each tested with the mode on and off. A design that still counted the excluded in-service bit, or that cleared a level request on acknowledge, would show the wrong intOut or request value. The cases also cover automatic end-of-interrupt with and without rotation, and rotating end-of-interrupt picking the top line under a moved base.

// File: rtl/pir_pkg.sv
package pir_pkg;

  parameter int PIR_LINES = 8;
  localparam int PIR_LW = $clog2(PIR_LINES);
  localparam int PIR_CASCADE_LINE = 2;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_EOI      = 3'd1,
    OP_EOI_ROT  = 3'd2,
    OP_SPEC     = 3'd3,
    OP_SPEC_ROT = 3'd4,
    OP_SET_BASE = 3'd5,
    OP_AROT_ON  = 3'd6,
    OP_AROT_OFF = 3'd7
  } pir_op_e;

  typedef struct packed {
    logic              ackTake;
    logic [PIR_LW-1:0] ackLine;
    logic              ackSetSvc;
    logic              svcClr;
    logic [PIR_LW-1:0] svcClrLine;
    logic              baseLoad;
    logic [PIR_LW-1:0] baseNew;
  } pir_strobe_t;

  // Priority number of the best set bit relative to base; PIR_LINES if empty.
  function automatic logic [PIR_LW:0] prioOf(input logic [PIR_LINES-1:0] req,
                                             input logic [PIR_LW-1:0] base);
    logic [PIR_LW:0]   p;
    logic [PIR_LW-1:0] idx;
    p = (PIR_LW+1)'(PIR_LINES);
    for (int k = PIR_LINES - 1; k >= 0; k--) begin
      idx = base + PIR_LW'(k);
      if (req[idx]) p = (PIR_LW+1)'(k);
    end
    return p;
  endfunction

endpackage

// File: rtl/pir_datapath.sv
module pir_datapath
  import pir_pkg::*;
#(
  parameter logic [PIR_LINES-1:0] TRIG_WRITABLE = 8'hFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIR_LINES-1:0] irqLines,
  input  logic                 maskWe,
  input  logic [PIR_LINES-1:0] maskIn,
  input  logic                 trigWe,
  input  logic [PIR_LINES-1:0] trigIn,
  input  logic                 modeSpecialMask,
  input  logic                 modeNested,
  input  logic                 isMaster,
  input  pir_strobe_t          strb,
  output logic [PIR_LINES-1:0] irrQ,
  output logic [PIR_LINES-1:0] isrQ,
  output logic [PIR_LINES-1:0] imrQ,
  output logic [PIR_LINES-1:0] trigQ,
  output logic [PIR_LW-1:0]    baseQ,
  output logic                 wantInt,
  output logic [PIR_LW-1:0]    wantLine,
  output logic                 topSvcValid,
  output logic [PIR_LW-1:0]    topSvcLine
);

  logic [PIR_LINES-1:0] lastQ;
  logic [PIR_LINES-1:0] pendReq;
  logic [PIR_LINES-1:0] svcMask;
  logic [PIR_LINES-1:0] isrNext;
  logic [PIR_LW:0]      pendPri;
  logic [PIR_LW:0]      svcPri;
  logic [PIR_LW:0]      topPri;

  // Request capture, one slice per line
  genvar gi;
  generate
    for (gi = 0; gi < PIR_LINES; gi++) begin : g_line
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          lastQ[gi] <= 1'b0;
          irrQ[gi]  <= 1'b0;
        end else begin
          lastQ[gi] <= irqLines[gi];
          if (trigQ[gi]) begin
            irrQ[gi] <= irqLines[gi];
          end else if (irqLines[gi] && !lastQ[gi]) begin
            irrQ[gi] <= 1'b1;
          end else if (strb.ackTake && (strb.ackLine == PIR_LW'(gi))) begin
            irrQ[gi] <= 1'b0;
          end
        end
      end

      AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        trigQ[gi] |=> (irrQ[gi] == $past(irqLines[gi]))); // R2
    end
  endgenerate

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imrQ  <= '0;
      trigQ <= '0;
    end else begin
      if (maskWe) imrQ <= maskIn;
      if (trigWe) trigQ <= trigIn & TRIG_WRITABLE;
    end
  end

  // In-service register and priority base
  always_comb begin
    isrNext = isrQ;
    if (strb.svcClr)    isrNext[strb.svcClrLine] = 1'b0;
    if (strb.ackSetSvc) isrNext[strb.ackLine]    = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isrQ  <= '0;
      baseQ <= '0;
    end else begin
      isrQ <= isrNext;
      if (strb.baseLoad) baseQ <= strb.baseNew;
    end
  end

  // Resolution
  always_comb begin
    pendReq = irrQ & ~imrQ;
    pendPri = prioOf(pendReq, baseQ);
    svcMask = isrQ;
    if (modeSpecialMask) svcMask = svcMask & ~imrQ;
    if (modeNested && isMaster) svcMask[PIR_CASCADE_LINE] = 1'b0;
    svcPri   = prioOf(svcMask, baseQ);
    wantInt  = !pendPri[PIR_LW] && (pendPri < svcPri);
    wantLine = baseQ + pendPri[PIR_LW-1:0];
    topPri      = prioOf(isrQ, baseQ);
    topSvcValid = !topPri[PIR_LW];
    topSvcLine  = baseQ + topPri[PIR_LW-1:0];
  end

  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ackSetSvc |=> isrQ[$past(strb.ackLine)]); // R6

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.svcClr && !strb.ackSetSvc && isrQ[strb.svcClrLine])
      |=> ($countones(isrQ) == $past($countones(isrQ)) - 1)); // R8

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackTake && !trigQ[strb.ackLine] &&
     !(irqLines[strb.ackLine] && !lastQ[strb.ackLine]))
      |=> !irrQ[$past(strb.ackLine)]); // R7

endmodule

// File: rtl/pir_control.sv
module pir_control
  import pir_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeAutoEoi,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [PIR_LW-1:0] cmdLine,
  input  logic              ackStrobe,
  input  logic              wantInt,
  input  logic [PIR_LW-1:0] wantLine,
  input  logic              topSvcValid,
  input  logic [PIR_LW-1:0] topSvcLine,
  output pir_strobe_t       strb,
  output logic              rotAeoiQ,
  output logic              intOut,
  output logic              ackValid,
  output logic [PIR_LW-1:0] ackLine
);

  pir_op_e op;

  always_comb begin
    op   = pir_op_e'(cmdOp);
    strb = '0;
    strb.ackTake   = ackStrobe && wantInt;
    strb.ackLine   = wantLine;
    strb.ackSetSvc = strb.ackTake && !modeAutoEoi;
    if (cmdValid) begin
      unique case (op)
        OP_EOI: begin
          strb.svcClr     = topSvcValid;
          strb.svcClrLine = topSvcLine;
        end
        OP_EOI_ROT: begin
          strb.svcClr     = topSvcValid;
          strb.svcClrLine = topSvcLine;
          strb.baseLoad   = topSvcValid;
          strb.baseNew    = topSvcLine + 1'b1;
        end
        OP_SPEC: begin
          strb.svcClr     = 1'b1;
          strb.svcClrLine = cmdLine;
        end
        OP_SPEC_ROT: begin
          strb.svcClr     = 1'b1;
          strb.svcClrLine = cmdLine;
          strb.baseLoad   = 1'b1;
          strb.baseNew    = cmdLine + 1'b1;
        end
        OP_SET_BASE: begin
          strb.baseLoad = 1'b1;
          strb.baseNew  = cmdLine + 1'b1;
        end
        default: ;
      endcase
    end
    if (strb.ackTake && modeAutoEoi && rotAeoiQ && !strb.baseLoad) begin
      strb.baseLoad = 1'b1;
      strb.baseNew  = wantLine + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rotAeoiQ <= 1'b0;
      intOut   <= 1'b0;
      ackValid <= 1'b0;
      ackLine  <= '0;
    end else begin
      if (cmdValid && op == OP_AROT_ON)  rotAeoiQ <= 1'b1;
      if (cmdValid && op == OP_AROT_OFF) rotAeoiQ <= 1'b0;
      intOut   <= wantInt;
      ackValid <= strb.ackTake;
      ackLine  <= strb.ackTake ? wantLine : '0;
    end
  end

  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |-> $past(ackStrobe)); // R3

endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import pir_pkg::*;
#(
  parameter logic [PIR_LINES-1:0] TRIG_WRITABLE = 8'hFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIR_LINES-1:0] irqLines,
  input  logic                 maskWe,
  input  logic [PIR_LINES-1:0] maskIn,
  input  logic                 trigWe,
  input  logic [PIR_LINES-1:0] trigIn,
  input  logic                 modeSpecialMask,
  input  logic                 modeNested,
  input  logic                 isMaster,
  input  logic                 modeAutoEoi,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [PIR_LW-1:0]    cmdLine,
  input  logic                 ackStrobe,
  output logic                 intOut,
  output logic                 ackValid,
  output logic [PIR_LW-1:0]    ackLine,
  output logic [PIR_LINES-1:0] reqOut,
  output logic [PIR_LINES-1:0] svcOut,
  output logic [PIR_LINES-1:0] trigOut,
  output logic [PIR_LW-1:0]    baseOut
);

  pir_strobe_t          strb;
  logic [PIR_LINES-1:0] imrQ;
  logic                 wantInt;
  logic [PIR_LW-1:0]    wantLine;
  logic                 topSvcValid;
  logic [PIR_LW-1:0]    topSvcLine;
  logic                 rotAeoiQ;

  pir_datapath #(.TRIG_WRITABLE(TRIG_WRITABLE)) dp_i (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines),
    .maskWe(maskWe), .maskIn(maskIn), .trigWe(trigWe), .trigIn(trigIn),
    .modeSpecialMask(modeSpecialMask), .modeNested(modeNested), .isMaster(isMaster),
    .strb(strb), .irrQ(reqOut), .isrQ(svcOut), .imrQ(imrQ), .trigQ(trigOut),
    .baseQ(baseOut), .wantInt(wantInt), .wantLine(wantLine),
    .topSvcValid(topSvcValid), .topSvcLine(topSvcLine)
  );

  pir_control ctl_i (
    .clk(clk), .rst_n(rst_n), .modeAutoEoi(modeAutoEoi),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLine(cmdLine), .ackStrobe(ackStrobe),
    .wantInt(wantInt), .wantLine(wantLine),
    .topSvcValid(topSvcValid), .topSvcLine(topSvcLine),
    .strb(strb), .rotAeoiQ(rotAeoiQ), .intOut(intOut),
    .ackValid(ackValid), .ackLine(ackLine)
  );

  AST_INT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> $past(|(reqOut & ~imrQ))); // R4

  AST_AEOI_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && wantInt && modeAutoEoi && rotAeoiQ && !cmdValid)
      |=> (baseOut == $past(wantLine) + 1'b1)); // R6

  AST_ACK_IDLE_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    (ackStrobe && !wantInt && !cmdValid) |=> $stable(svcOut)); // R11

endmodule

// File: tb/prio_irq_resolver_tb.sv
`timescale 1ns/1ps
module prio_irq_resolver_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqLines = '0;
  logic       maskWe = 1'b0;
  logic [7:0] maskIn = '0;
  logic       trigWe = 1'b0;
  logic [7:0] trigIn = '0;
  logic       modeSpecialMask = 1'b0;
  logic       modeNested = 1'b0;
  logic       isMaster = 1'b0;
  logic       modeAutoEoi = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [2:0] cmdLine = '0;
  logic       ackStrobe = 1'b0;
  logic       intOut;
  logic       ackValid;
  logic [2:0] ackLine;
  logic [7:0] reqOut;
  logic [7:0] svcOut;
  logic [7:0] trigOut;
  logic [2:0] baseOut;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  prio_irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines),
    .maskWe(maskWe), .maskIn(maskIn), .trigWe(trigWe), .trigIn(trigIn),
    .modeSpecialMask(modeSpecialMask), .modeNested(modeNested), .isMaster(isMaster),
    .modeAutoEoi(modeAutoEoi), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLine(cmdLine),
    .ackStrobe(ackStrobe), .intOut(intOut), .ackValid(ackValid), .ackLine(ackLine),
    .reqOut(reqOut), .svcOut(svcOut), .trigOut(trigOut), .baseOut(baseOut)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int best(input int bits, input int base);
    for (int k = 0; k < 8; k++)
      if (bits[(k + base) % 8]) return (k + base) % 8;
    return -1;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] pat);
    @(negedge clk) irqLines = pat;
    @(negedge clk) irqLines = '0;
    @(negedge clk);
  endtask

  task automatic doCmd(input int op, input int line);
    @(negedge clk) begin cmdValid = 1'b1; cmdOp = 3'(op); cmdLine = 3'(line); end
    @(negedge clk) cmdValid = 1'b0;
  endtask

  task automatic doAck(input int expV, input int expL, input string tag);
    @(negedge clk) ackStrobe = 1'b1;
    @(negedge clk) ackStrobe = 1'b0;
    check({tag, " valid"}, ackValid, expV);
    if (expV != 0) check({tag, " line"}, ackLine, expL);
  endtask

  task automatic writeMask(input logic [7:0] m);
    @(negedge clk) begin maskWe = 1'b1; maskIn = m; end
    @(negedge clk) maskWe = 1'b0;
  endtask

  task automatic writeTrig(input logic [7:0] t);
    @(negedge clk) begin trigWe = 1'b1; trigIn = t; end
    @(negedge clk) trigWe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int rem;
    int e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(1);
    check("R1 intOut reset", intOut, 0);
    check("R1 ackValid reset", ackValid, 0);
    check("R1 req reset", reqOut, 0);
    check("R1 svc reset", svcOut, 0);
    check("R1 trig reset", trigOut, 0);
    check("R1 base reset", baseOut, 0);

    // Exhaustive sweep: every pattern under every base, drained by acknowledges
    for (int b = 0; b < 8; b++) begin
      doCmd(5, (b + 7) % 8);
      check("R9 set base", baseOut, b);
      for (int pat = 0; pat < 256; pat++) begin
        pulse(8'(pat));
        check("R4 int after inject", intOut, (pat != 0) ? 1 : 0);
        rem = pat;
        while (rem != 0) begin
          e = best(rem, b);
          doAck(1, e, "R3 sweep ack");
          check("R6 svc after ack", svcOut, 1 << e);
          rem = rem & ~(1 << e);
          doCmd(1, 0);
        end
        doAck(0, 0, "R11 empty ack");
        check("R7 edge req drained", reqOut, 0);
        check("R8 svc drained", svcOut, 0);
      end
    end

    doCmd(5, 7);
    check("R9 base back to 0", baseOut, 0);

    // Trigger mask and level/edge behaviour on acknowledge
    writeTrig(8'hFF);
    check("R10 forced edge lines", trigOut, 8'hFC);
    @(negedge clk) irqLines = 8'h20;
    step(2);
    check("R2 level req set", reqOut, 8'h20);
    check("R4 level int", intOut, 1);
    doAck(1, 5, "R3 level ack");
    check("R7 level req kept", reqOut, 8'h20);
    doCmd(1, 0);
    @(negedge clk) irqLines = 8'h00;
    step(1);
    check("R2 level req follows low", reqOut, 0);
    @(negedge clk) irqLines = 8'h01;
    step(2);
    doAck(1, 0, "R10 forced edge ack");
    step(2);
    check("R7 edge req cleared while held", reqOut, 0);
    check("R2 held edge no retrigger", intOut, 0);
    doCmd(1, 0);
    @(negedge clk) irqLines = 8'h00;
    writeTrig(8'h00);

    // Strict comparison against in-service
    pulse(8'h10);
    doAck(1, 4, "R3 ack4");
    pulse(8'h40);
    check("R4 lower than svc blocked", intOut, 0);
    pulse(8'h10);
    check("R4 equal to svc blocked", intOut, 0);
    pulse(8'h02);
    check("R4 higher than svc raises", intOut, 1);
    doAck(1, 1, "R3 ack1");
    check("R6 svc two bits", svcOut, 8'h12);
    doCmd(3, 1);
    check("R9 specific eoi", svcOut, 8'h10);

    // Special mask
    writeMask(8'h10);
    @(negedge clk) modeSpecialMask = 1'b1;
    step(2);
    check("R5 special mask ignores svc4", intOut, 1);
    @(negedge clk) modeSpecialMask = 1'b0;
    step(2);
    check("R5 special mask off blocks", intOut, 0);
    writeMask(8'h00);
    doCmd(3, 4);
    check("R9 specific eoi 4", svcOut, 0);
    doAck(1, 4, "R3 drain 4");
    doCmd(1, 0);
    doAck(1, 6, "R3 drain 6");
    doCmd(1, 0);
    check("R8 drained", svcOut, 0);

    // Nested master
    pulse(8'h04);
    doAck(1, 2, "R3 ack2");
    pulse(8'h20);
    check("R4 blocked by svc2", intOut, 0);
    @(negedge clk) begin modeNested = 1'b1; isMaster = 1'b1; end
    step(2);
    check("R5 nested master ignores svc2", intOut, 1);
    @(negedge clk) isMaster = 1'b0;
    step(2);
    check("R5 nested non-master blocks", intOut, 0);
    @(negedge clk) modeNested = 1'b0;
    doCmd(4, 2);
    check("R9 specific rotate svc", svcOut, 0);
    check("R9 specific rotate base", baseOut, 3);
    doAck(1, 5, "R3 ack5 base3");
    doCmd(1, 0);

    // Rotating nonspecific EOI
    doCmd(5, 7);
    pulse(8'h20);
    doAck(1, 5, "R3 ack5");
    pulse(8'h04);
    check("R4 line2 above svc5", intOut, 1);
    doAck(1, 2, "R3 ack2 nested");
    check("R6 svc 2 and 5", svcOut, 8'h24);
    doCmd(2, 0);
    check("R8 rotating eoi svc", svcOut, 8'h20);
    check("R8 rotating eoi base", baseOut, 3);
    doCmd(1, 0);
    check("R8 eoi under base3", svcOut, 0);
    doCmd(1, 0);
    check("R8 eoi empty no base change", baseOut, 3);

    // Automatic end-of-interrupt
    @(negedge clk) modeAutoEoi = 1'b1;
    pulse(8'h08);
    doAck(1, 3, "R6 aeoi ack");
    check("R6 aeoi no svc", svcOut, 0);
    check("R6 aeoi base kept", baseOut, 3);
    doCmd(6, 0);
    pulse(8'h40);
    doAck(1, 6, "R6 aeoi rot ack");
    check("R6 aeoi rot base", baseOut, 7);
    check("R6 aeoi rot no svc", svcOut, 0);
    doCmd(7, 0);
    pulse(8'h02);
    doAck(1, 1, "R6 aeoi no rot ack");
    check("R6 rot disabled base", baseOut, 7);
    @(negedge clk) modeAutoEoi = 1'b0;

    // Masking
    writeMask(8'h01);
    pulse(8'h01);
    check("R11 masked no int", intOut, 0);
    doAck(0, 0, "R11 masked ack");
    check("R11 masked svc", svcOut, 0);
    check("R11 masked req kept", reqOut, 8'h01);
    writeMask(8'h00);
    step(2);
    check("R11 unmask raises", intOut, 1);
    doAck(1, 0, "R11 unmasked ack");
    doCmd(0, 0);
    check("R9 nop keeps svc", svcOut, 8'h01);
    doCmd(1, 0);
    check("R8 final svc", svcOut, 0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule